// File: doc/BRIEF.md
# Universal Latch/Register Bus Driver

This block drives a 20-channel data bus from a per-channel storage bit. The bit can act in two ways, picked by an active-low latch-enable control. When that control is low, the bit is transparent and the output follows the input. When it is high, the bit works as an edge-triggered register: it loads only when the capture clock CP rises, and holds its value otherwise. A separate active-low output enable decides whether the outputs drive the bus or float. Storage keeps its contents while the outputs float.

The design is a synchronous model of a part that is asynchronous at its pins. A fast system clock samples CP, the two enables and the data through a chain of synchroniser flops. The controls and the data pass through the same chain, so they stay aligned to the same sample. A rising CP edge is a 0-to-1 step between two consecutive synchronised samples of CP. The three-state pins are shown as two vectors: a data vector, and a per-bit drive vector in which 1 means driven and 0 means high impedance.

Top module: `latchreg_driver`

## Requirements
- R1: A synchronous active-high reset clears the stored value to zero. On the clock after reset is released, `y_data` reads zero.
- R2: `y_en` is all ones (driving) exactly when `oe_n_in`, sampled two clocks earlier, was 0. Otherwise `y_en` is all zeros (high impedance).
- R3: While `le_n_in` is 0, `y_data` follows `a_in` with a three-clock latency, whatever CP is doing.
- R4: While `le_n_in` is 1, a CP sample of 1 that follows a CP sample of 0 loads `a_in` from the same sample. That value reaches `y_data` three clocks after the sample.
- R5: While `le_n_in` is 1 and CP shows no 0-to-1 step, `y_data` holds its value even when `a_in` changes.
- R6: If `le_n_in` rises while CP is already high, the value that was transparent just before is held. No capture follows until CP falls and rises again.
- R7: Raising `oe_n_in` does not disturb storage. Lowering it again drives the held value at once, with no reload.
- R8: A CP level held high through reset and after it is not a rising edge. `y_data` stays zero until CP really rises.
- R9: If `le_n_in` goes high in the same sample in which CP rises, the data of that sample is captured. A capture made in the same sample as an output disable is kept and appears on re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_in | input | 1 | Asynchronous capture clock |
| le_n_in | input | 1 | Latch enable, active low (low = transparent) |
| oe_n_in | input | 1 | Output enable, active low |
| a_in | input | WIDTH | Data inputs |
| y_data | output | WIDTH | Stored data presented to the bus |
| y_en | output | WIDTH | Per-bit drive enable, 1 = driven, 0 = high impedance |

## Verification
Two events can land in the same synchronised sample. A CP rising edge can meet a latch-enable change, and a capture can meet an output-enable change. The bench provokes each one by changing both inputs at the same falling clock edge, so one rising edge samples them together. It then judges the case in two ways. First, it reads the captured value back after re-enabling or settling, against a fixed expected word. Second, a behavioural model of the function table runs on delayed input history and is compared on every clock, across directed phases and a long random phase.

// File: rtl/latchreg_pkg.sv
package latchreg_pkg;

   // Control bundle carried through the synchroniser beside the data.
   typedef struct packed {
      logic cp;
      logic le_n;
      logic oe_n;
   } lr_ctrl_t;

   localparam int LR_CTRL_BITS = $bits(lr_ctrl_t);

endpackage

// File: rtl/latchreg_sync.sv
module latchreg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("latchreg_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("latchreg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/latchreg_edge.sv
module latchreg_edge (
   input  logic clk,
   input  logic level,
   output logic rise
);

   // The previous sample tracks the level through reset too, so a level
   // that is already high when reset ends never looks like an edge.
   logic prev;

   always_ff @(posedge clk) prev <= level;

   assign rise = level & ~prev;

endmodule

// File: rtl/latchreg_cell.sv
module latchreg_cell (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= 1'b0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/latchreg_driver.sv
module latchreg_driver
   import latchreg_pkg::*;
#(
   parameter int WIDTH       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cp_in,
   input  logic             le_n_in,
   input  logic             oe_n_in,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] y_data,
   output logic [WIDTH-1:0] y_en
);

   localparam int BUS_BITS = WIDTH + LR_CTRL_BITS;

   if (WIDTH < 1) begin : g_bad_width
      $error("latchreg_driver: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("latchreg_driver: SYNC_STAGES must be at least 2");
   end

   lr_ctrl_t         ctrl_raw, ctrl_s;
   logic [WIDTH-1:0] data_s;
   logic             cp_rise;
   logic             load;

   assign ctrl_raw = '{cp: cp_in, le_n: le_n_in, oe_n: oe_n_in};

   // Controls and data share one chain so they stay aligned sample by sample.
   latchreg_sync #(.WIDTH(BUS_BITS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   ({a_in, ctrl_raw}),
      .q   ({data_s, ctrl_s})
   );

   latchreg_edge u_edge (
      .clk   (clk),
      .level (ctrl_s.cp),
      .rise  (cp_rise)
   );

   // Transparent while the latch enable is low, otherwise load on a CP rise.
   assign load = ~ctrl_s.le_n | cp_rise;

   for (genvar b = 0; b < WIDTH; b++) begin : g_chan
      latchreg_cell u_cell (
         .clk  (clk),
         .rst  (rst),
         .load (load),
         .d    (data_s[b]),
         .q    (y_data[b])
      );
   end

   assign y_en = {WIDTH{~ctrl_s.oe_n}};

endmodule

// File: rtl/latchreg_driver_chk.sv
module latchreg_driver_chk #(
   parameter int WIDTH       = 20,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             cp_in,
   input logic             le_n_in,
   input logic             oe_n_in,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] y_data,
   input logic [WIDTH-1:0] y_en
);

   localparam int HDEPTH = SYNC_STAGES + 2;
   localparam int CW     = $clog2(HDEPTH + 2) + 1;

   // Bit k of each history register holds the port value k+1 clocks back.
   logic [HDEPTH-1:0] h_cp, h_le, h_oe;
   logic [WIDTH-1:0]  h_a [HDEPTH];
   logic [CW-1:0]     cyc;
   logic              ready;

   always_ff @(posedge clk) begin
      h_cp <= {h_cp[HDEPTH-2:0], cp_in};
      h_le <= {h_le[HDEPTH-2:0], le_n_in};
      h_oe <= {h_oe[HDEPTH-2:0], oe_n_in};
      h_a[0] <= a_in;
      for (int k = 1; k < HDEPTH; k++) h_a[k] <= h_a[k-1];
   end

   always_ff @(posedge clk) begin
      if (rst)                           cyc <= '0;
      else if (cyc < CW'(HDEPTH + 1))    cyc <= cyc + 1'b1;
   end

   assign ready = (cyc >= CW'(HDEPTH));

   // R1
   a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (y_data == '0));

   // R2
   a_r2_drive_off: assert property (@(posedge clk) disable iff (rst)
      (ready && h_oe[SYNC_STAGES-1]) |-> (y_en == '0));
   a_r2_drive_on: assert property (@(posedge clk) disable iff (rst)
      (ready && !h_oe[SYNC_STAGES-1]) |-> (y_en == '1));

   // R3
   a_r3_transparent: assert property (@(posedge clk) disable iff (rst)
      (ready && !h_le[SYNC_STAGES]) |-> (y_data == h_a[SYNC_STAGES]));

   // R4, R9
   a_r4_capture: assert property (@(posedge clk) disable iff (rst)
      (ready && h_le[SYNC_STAGES] && h_cp[SYNC_STAGES] && !h_cp[SYNC_STAGES+1])
      |-> (y_data == h_a[SYNC_STAGES]));

   // R5, R6, R7
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (ready && h_le[SYNC_STAGES] && !(h_cp[SYNC_STAGES] && !h_cp[SYNC_STAGES+1]))
      |-> (y_data == $past(y_data)));

endmodule

bind latchreg_driver latchreg_driver_chk #(
   .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst(rst), .cp_in(cp_in), .le_n_in(le_n_in), .oe_n_in(oe_n_in),
   .a_in(a_in), .y_data(y_data), .y_en(y_en)
);

// File: tb/latchreg_driver_test.sv
`timescale 1ns/1ps
module latchreg_driver_test;

   localparam int W = 20;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cp = 1'b0, le_n = 1'b1, oe_n = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] y_data, y_en;

   latchreg_driver uut (
      .clk(clk), .rst(rst), .cp_in(cp), .le_n_in(le_n), .oe_n_in(oe_n),
      .a_in(a), .y_data(y_data), .y_en(y_en)
   );

   always #2.5 clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   int    ncyc   = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // Reference model: input history {cp, le_n, oe_n, a}, newest last.
   logic [W+2:0] hist [$];
   logic [W-1:0] exp_q  = '0;
   logic [W-1:0] exp_en = '0;

   always @(posedge clk) begin
      logic [W+2:0] s_now, s_old;
      hist.push_back({cp, le_n, oe_n, a});
      if (hist.size() > 4) void'(hist.pop_front());
      ncyc++;
      if (hist.size() >= 2) exp_en = hist[hist.size()-2][W] ? '0 : '1;
      if (rst) exp_q = '0;
      else if (hist.size() == 4) begin
         s_now = hist[1];
         s_old = hist[0];
         if (!s_now[W+1])                     exp_q = s_now[W-1:0];
         else if (s_now[W+2] && !s_old[W+2])  exp_q = s_now[W-1:0];
      end
   end

   task automatic model_cmp();
      if (ncyc >= 4) begin
         checks++;
         if (y_data !== exp_q || y_en !== exp_en) begin
            fails++;
            $display("FAIL %s model: y_data=%h y_en=%h expected y_data=%h y_en=%h",
                     cur_req, y_data, y_en, exp_q, exp_en);
         end
      end
   endtask

   task automatic tick(int n);
      repeat (n) begin
         @(negedge clk);
         model_cmp();
      end
   endtask

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s direct: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      // R1 / R2: reset with outputs disabled
      cur_req = "R1";
      tick(6);
      rst = 1'b0;
      tick(1);
      chk("R1", y_data, '0);
      chk("R2", y_en, '0);

      cur_req = "R2";
      oe_n = 1'b0;
      tick(4);
      chk("R2", y_en, '1);
      chk("R5", y_data, '0);

      // R3: transparent, CP activity irrelevant
      cur_req = "R3";
      le_n = 1'b0; a = 20'hABCDE;
      tick(4);
      chk("R3", y_data, 20'hABCDE);
      for (int k = 0; k < 40; k++) begin
         a = W'($urandom); cp = 1'($urandom);
         tick(1);
      end
      cp = 1'b1; a = 20'h12345;
      tick(4);
      chk("R3", y_data, 20'h12345);

      // R6: LE rises while CP already high
      cur_req = "R6";
      cp = 1'b1; a = 20'hA5C3E;
      tick(4);
      le_n = 1'b1;
      tick(1);
      a = 20'h5A3C1;
      tick(5);
      chk("R6", y_data, 20'hA5C3E);

      // R5: hold with CP steady low and high
      cur_req = "R5";
      cp = 1'b0; a = 20'h0F0F0;
      tick(5);
      chk("R5", y_data, 20'hA5C3E);

      // R4: capture on CP rise
      cur_req = "R4";
      cp = 1'b1; a = 20'h3C3C3;
      tick(5);
      chk("R4", y_data, 20'h3C3C3);
      cur_req = "R5";
      a = 20'hFFFFF;
      tick(5);
      chk("R5", y_data, 20'h3C3C3);

      // R7: disable, change data, re-enable
      cur_req = "R7";
      oe_n = 1'b1; a = 20'h11111;
      tick(4);
      chk("R7", y_en, '0);
      oe_n = 1'b0;
      tick(3);
      chk("R7", y_en, '1);
      chk("R7", y_data, 20'h3C3C3);

      // R9: LE rise together with CP rise
      cur_req = "R9";
      cp = 1'b0; le_n = 1'b0; a = 20'h76543;
      tick(4);
      le_n = 1'b1; cp = 1'b1; a = 20'h89ABC;
      tick(5);
      chk("R9", y_data, 20'h89ABC);
      // R9: capture together with output disable
      cp = 1'b0;
      tick(4);
      oe_n = 1'b1; cp = 1'b1; a = 20'h2468A;
      tick(5);
      chk("R9", y_en, '0);
      oe_n = 1'b0; a = 20'h00001;
      tick(4);
      chk("R9", y_data, 20'h2468A);
      chk("R9", y_en, '1);

      // R8: CP held high through reset is not an edge
      cur_req = "R8";
      rst = 1'b1; cp = 1'b1; le_n = 1'b1; a = 20'hCAFE5;
      tick(6);
      rst = 1'b0;
      tick(6);
      chk("R8", y_data, '0);
      cur_req = "R4";
      cp = 1'b0;
      tick(3);
      cp = 1'b1;
      tick(4);
      chk("R4", y_data, 20'hCAFE5);

      // Random mix of every control against the model
      cur_req = "random R3 R4 R5 R2";
      for (int k = 0; k < 3000; k++) begin
         cp   = 1'($urandom);
         le_n = ($urandom % 4) != 0;
         oe_n = ($urandom % 5) == 0;
         a    = W'($urandom);
         tick(1);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule